// File: doc/BRIEF.md
# Master Clock Output Selector

This block chooses one of several master clock inputs and drives the master clock output pin. The output can be turned off, carry the internal DSP master clock, carry half of that clock, or pass the chosen input straight through. The internal DSP clock either equals the chosen input or is obtained by doubling it. The choice depends on a rate setting that says whether the input already runs at the full rate (512fs) or at half that rate (256fs).

The block is described as synchronous logic on a sampling clock `clk`. Every clock line (inputs and output) is a level sampled once per `clk` cycle. The doubler is modelled by detecting edges of the chosen input: each input edge gives a one-cycle high phase of the internal clock. The divided clock follows the input in inverted form when the input is at half rate. It does not apply that inversion to the pass-through path. A new output mode is adopted only when the divided clock rises, so a pulse that has started always runs to its full length.

The configuration inputs are plain levels that the block samples on every cycle. An input select code that does not name an existing input leaves the current selection as it is.

Top module: `mclk_out_sel`

## Requirements
- R1: While `rst_n` is low, and in the first sampled cycle after it rises, `mclk_out` is 0. Reset leaves the input selection at input 0, the rate at full (0) and the output mode at off (00), so an out-of-range select code given just after reset keeps input 0 in use.
- R2: Output mode code 00 (off) holds `mclk_out` at 0 whatever the inputs do.
- R3: Output mode code 01 drives the internal clock. At rate setting 0 the internal clock is the chosen input, and `mclk_out` equals the chosen input as it was sampled three cycles earlier.
- R4: At rate setting 1 the internal clock is high for one cycle after each edge of the chosen input. In mode 01, `mclk_out` equals the XOR of the chosen input sampled three and four cycles earlier.
- R5: Output mode code 10 at rate setting 0 gives the divided clock. It toggles on every rising edge of the internal clock, so with an input that toggles every cycle, `mclk_out` equals the inverse of its own value two cycles earlier.
- R6: Output mode code 10 at rate setting 1 gives the divided clock phase-inverted against the half-rate input. For an input that toggles every two cycles, `mclk_out` equals the inverse of the chosen input sampled three cycles earlier.
- R7: Output mode code 11 passes the chosen input through without inversion. `mclk_out` equals the chosen input sampled two cycles earlier.
- R8: Select codes 0, 1 and 2 choose inputs bit 0, bit 1 and bit 2 of `mclk_in`. Code 3 keeps the previous valid selection.
- R9: A change of output mode takes effect only in the cycle in which the divided clock rises. With rate setting 0 and an input that toggles every cycle, every high pulse on `mclk_out` lasts exactly two cycles, however often the mode switches between 00 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the block |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclk_in | input | 3 | Sampled levels of the master clock inputs |
| cfg_in_sel | input | 2 | Input select code (3 keeps the previous choice) |
| cfg_in_rate | input | 1 | 0: input is full rate; 1: input is half rate and gets doubled |
| cfg_out_mode | input | 2 | 00 off, 01 internal clock, 10 divided clock, 11 pass-through |
| mclk_out | output | 1 | Master clock output level |

## Verification
Each input toggles with its own half-period of one, two or three cycles. A waveform that matches the expected delayed copy therefore also shows which input was chosen and that code 3 changed nothing. The same half-rate input is run through the internal, divided and pass-through modes. This separates the doubled clock (an XOR of two samples), the inverted divided clock and the uninverted pass-through, which share a source but differ in polarity and shape. The full-rate input in divided mode checks the period. Rapid switching between the off and divided modes, at offsets that do not line up with the divider, shows whether any pulse comes out shortened.

// File: rtl/mco_pkg.sv
package mco_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_FULL = 2'b01,
        MODE_HALF = 2'b10,
        MODE_THRU = 2'b11
    } mco_mode_e;

endpackage

// File: rtl/mco_src_sel.sv
// Input selection register and sampling of the chosen clock line.
module mco_src_sel #(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] mclk_in,
    input  logic [SEL_W-1:0]   cfg_in_sel,
    output logic [SEL_W-1:0]   sel_q,
    output logic               src_q,
    output logic               src_p_q
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             src;
        logic             src_p;
    } src_state_t;

    src_state_t st_d, st_q;
    logic [NUM_SRC-1:0] hit;

    // One match line per input
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
        assign hit[g] = (st_q.sel == SEL_W'(g)) & mclk_in[g];
    end

    always_comb begin
        st_d = st_q;
        if (int'(cfg_in_sel) < NUM_SRC) begin
            st_d.sel = cfg_in_sel;
        end
        st_d.src   = |hit;
        st_d.src_p = st_q.src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q   = st_q.sel;
    assign src_q   = st_q.src;
    assign src_p_q = st_q.src_p;

endmodule

// File: rtl/mco_clk_gen.sv
// Internal clock (direct or edge-doubled) and the divide-by-two stage.
module mco_clk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_in_rate,
    input  logic src_q,
    input  logic src_p_q,
    output logic rate_q,
    output logic dsp_q,
    output logic div_q,
    output logic div_rise_d
);

    typedef struct packed {
        logic rate;
        logic dsp;
        logic div;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic dsp_up;

    always_comb begin
        st_d      = st_q;
        st_d.rate = cfg_in_rate;
        // half-rate input: one high cycle per input edge doubles the rate
        st_d.dsp  = st_q.rate ? (src_q ^ src_p_q) : src_q;
        dsp_up    = st_d.dsp & ~st_q.dsp;
        if (dsp_up) begin
            // half-rate input: lock divider to the inverse of the input
            st_d.div = st_q.rate ? ~src_q : ~st_q.div;
        end
        div_rise_d = st_d.div & ~st_q.div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_q = st_q.rate;
    assign dsp_q  = st_q.dsp;
    assign div_q  = st_q.div;

endmodule

// File: rtl/mco_out_stage.sv
// Output mode register (updated on divided-clock rise) and output mux.
module mco_out_stage
    import mco_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_out_mode,
    input  logic       div_rise_d,
    input  logic       src_q,
    input  logic       dsp_q,
    input  logic       div_q,
    output logic [1:0] mode_q,
    output logic       mclk_out
);

    typedef struct packed {
        mco_mode_e mode;
        logic      out;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (div_rise_d) begin
            st_d.mode = mco_mode_e'(cfg_out_mode);
        end
        unique case (st_q.mode)
            MODE_OFF:  st_d.out = 1'b0;
            MODE_FULL: st_d.out = dsp_q;
            MODE_HALF: st_d.out = div_q;
            MODE_THRU: st_d.out = src_q;
            default:   st_d.out = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_OFF, out: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q   = st_q.mode;
    assign mclk_out = st_q.out;

endmodule

// File: rtl/mclk_out_sel.sv
module mclk_out_sel #(
    parameter int NUM_SRC = 3,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] mclk_in,
    input  logic [SEL_W-1:0]   cfg_in_sel,
    input  logic               cfg_in_rate,
    input  logic [1:0]         cfg_out_mode,
    output logic               mclk_out
);

    logic [SEL_W-1:0] sel_q;
    logic             src_q;
    logic             src_p_q;
    logic             rate_q;
    logic             dsp_q;
    logic             div_q;
    logic             div_rise_d;
    logic [1:0]       mode_q;

    mco_src_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk_in    (mclk_in),
        .cfg_in_sel (cfg_in_sel),
        .sel_q      (sel_q),
        .src_q      (src_q),
        .src_p_q    (src_p_q)
    );

    mco_clk_gen u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_in_rate (cfg_in_rate),
        .src_q       (src_q),
        .src_p_q     (src_p_q),
        .rate_q      (rate_q),
        .dsp_q       (dsp_q),
        .div_q       (div_q),
        .div_rise_d  (div_rise_d)
    );

    mco_out_stage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_out_mode (cfg_out_mode),
        .div_rise_d   (div_rise_d),
        .src_q        (src_q),
        .dsp_q        (dsp_q),
        .div_q        (div_q),
        .mode_q       (mode_q),
        .mclk_out     (mclk_out)
    );

endmodule

// File: rtl/mco_checker.sv
module mco_checker #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] cfg_in_sel,
    input logic [SEL_W-1:0] sel_q,
    input logic [1:0]       mode_q,
    input logic             src_q,
    input logic             dsp_q,
    input logic             div_q,
    input logic             mclk_out
);

    assert_off_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00) |=> !mclk_out);

    assert_full_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b01) |=> (mclk_out == $past(dsp_q)));

    assert_half_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10) |=> (mclk_out == $past(div_q)));

    assert_thru_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b11) |=> (mclk_out == $past(src_q)));

    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_in_sel == SEL_W'(3)) |=> $stable(sel_q));

    assert_mode_on_div_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $rose(div_q));

endmodule

bind mclk_out_sel mco_checker #(.SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_in_sel (cfg_in_sel),
    .sel_q      (sel_q),
    .mode_q     (mode_q),
    .src_q      (src_q),
    .dsp_q      (dsp_q),
    .div_q      (div_q),
    .mclk_out   (mclk_out)
);

// File: tb/mclk_out_sel_bench.sv
module mclk_out_sel_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mclk_in;
    logic [1:0] cfg_in_sel;
    logic       cfg_in_rate;
    logic [1:0] cfg_out_mode;
    logic       mclk_out;

    always #10 clk = ~clk;

    mclk_out_sel u_mclk_out_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .mclk_in      (mclk_in),
        .cfg_in_sel   (cfg_in_sel),
        .cfg_in_rate  (cfg_in_rate),
        .cfg_out_mode (cfg_out_mode),
        .mclk_out     (mclk_out)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic       out_s;
    logic       po [0:1];
    logic [2:0] hist [0:3];
    logic [2:0] ph [0:3];
    logic [2:0] lvl;
    int         cnt [3];
    int         hp [3];

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // One cycle: sample output, keep input history, drive next inputs
    task automatic tick();
        @(negedge clk);
        po[1] = po[0];
        po[0] = out_s;
        out_s = mclk_out;
        for (int k = 0; k < 4; k++) ph[k] = hist[k];
        for (int i = 0; i < 3; i++) begin
            cnt[i]++;
            if (cnt[i] >= hp[i]) begin
                cnt[i] = 0;
                lvl[i] = ~lvl[i];
            end
        end
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = lvl;
        mclk_in = lvl;
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setup(logic [1:0] sel, logic rate, logic [1:0] mode);
        cfg_in_sel   = sel;
        cfg_in_rate  = rate;
        cfg_out_mode = mode;
        settle(12);
    endtask

    task automatic t_reset();
        rst_n        = 1'b0;
        cfg_in_sel   = 2'd3;
        cfg_in_rate  = 1'b0;
        cfg_out_mode = 2'b11;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R1 low in reset", out_s, 1'b0);
        end
        rst_n = 1'b1;
        tick();
        chk("R1 low after reset", out_s, 1'b0);
        settle(12);
        for (int i = 0; i < 12; i++) begin
            tick();
            chk("R1 select defaults to input 0", out_s, ph[1][0]);
        end
    endtask

    task automatic t_off();
        setup(2'd0, 1'b0, 2'b00);
        for (int i = 0; i < 16; i++) begin
            tick();
            chk("R2 off mode low", out_s, 1'b0);
        end
    endtask

    task automatic t_full_direct();
        setup(2'd0, 1'b0, 2'b01);
        for (int i = 0; i < 16; i++) begin
            tick();
            chk("R3 internal clock direct", out_s, ph[2][0]);
        end
    endtask

    task automatic t_full_doubled();
        setup(2'd1, 1'b1, 2'b01);
        for (int i = 0; i < 16; i++) begin
            tick();
            chk("R4 doubled internal clock", out_s, ph[2][1] ^ ph[3][1]);
        end
    endtask

    task automatic t_half_direct();
        setup(2'd0, 1'b0, 2'b10);
        for (int i = 0; i < 16; i++) begin
            tick();
            chk("R5 divided period", out_s, ~po[1]);
        end
    endtask

    task automatic t_half_inverted();
        setup(2'd1, 1'b1, 2'b10);
        for (int i = 0; i < 16; i++) begin
            tick();
            chk("R6 divided clock inverted", out_s, ~ph[2][1]);
        end
    endtask

    task automatic t_thru();
        setup(2'd1, 1'b1, 2'b11);
        for (int i = 0; i < 16; i++) begin
            tick();
            chk("R7 pass-through uninverted", out_s, ph[1][1]);
        end
    endtask

    task automatic t_select();
        setup(2'd2, 1'b0, 2'b11);
        for (int i = 0; i < 12; i++) begin
            tick();
            chk("R8 select input 2", out_s, ph[1][2]);
        end
        setup(2'd3, 1'b0, 2'b11);
        for (int i = 0; i < 12; i++) begin
            tick();
            chk("R8 code 3 holds input 2", out_s, ph[1][2]);
        end
        setup(2'd1, 1'b0, 2'b11);
        for (int i = 0; i < 12; i++) begin
            tick();
            chk("R8 select input 1", out_s, ph[1][1]);
        end
    endtask

    task automatic t_no_trunc();
        int run = 0;
        int pulses = 0;
        setup(2'd0, 1'b0, 2'b00);
        for (int i = 0; i < 90; i++) begin
            if (i % 5 == 0) cfg_out_mode = (cfg_out_mode == 2'b00) ? 2'b10 : 2'b00;
            if (i % 7 == 3) cfg_out_mode = ~cfg_out_mode & 2'b10;
            tick();
            if (out_s) begin
                run++;
            end else if (run != 0) begin
                pulses++;
                chk("R9 pulse length two", (run == 2), 1'b1);
                run = 0;
            end
        end
        chk("R9 pulses seen", (pulses > 0), 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        out_s   = 1'b0;
        po[0]   = 1'b0;
        po[1]   = 1'b0;
        lvl     = 3'b000;
        mclk_in = 3'b000;
        hp[0] = 1; hp[1] = 2; hp[2] = 3;
        for (int i = 0; i < 3; i++) cnt[i] = 0;
        for (int k = 0; k < 4; k++) begin
            hist[k] = 3'b000;
            ph[k]   = 3'b000;
        end
        t_reset();
        t_off();
        t_full_direct();
        t_full_doubled();
        t_half_direct();
        t_half_inverted();
        t_thru();
        t_select();
        t_no_trunc();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule